// File: doc/BRIEF.md
# I2C Loopback Self-Test Sequencer

This block runs a self-test on an I2C master controller and an I2C slave controller that share one device and are wired to each other. It does not touch the bus. It drives only the request, data and byte-count inputs of the two controllers and waits on their handshake flags.

The test has two phases:

- **Phase one, master to slave.** The master writes a short byte pattern, and the slave's receive path returns those bytes for checking.
- **Phase two, slave to master.** The master issues a read, and the slave supplies the same pattern.

Every received byte is compared with the value the pattern generator computes for its position. The first byte seen in each direction is kept on a display output. The run ends only once the master has released its busy flag. If any handshake stalls for longer than a timeout, the run ends early with an error.

The test pattern is `SEED + k` modulo 256 for byte position k, with `SEED` defaulting to 0xA5 and the byte count `NBYTES` defaulting to 4. A single-cycle `start` pulse launches a run from idle or from the finished state.

Top module: `i2c_loopback_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, all four request outputs, `done`, `pass`, `err`, `led_m2s` and `led_s2m` are zero.
- R2: A `start` seen in idle or done gives a one-cycle `m_wr_req` pulse in the next cycle, with `m_cmd`=CMD, `m_nbytes`=NBYTES and `m_data`=0xA5. After k `m_tx_next` strobes during the write phase, `m_data` is 0xA5+k (mod 256).
- R3: The requests come in the order `m_wr_req`, `s_rd_req`, `m_rd_req`, `s_wr_req`, and each is a single-cycle pulse. `s_rd_req` follows `m_wr_done` and then `s_rd_ready`. `m_rd_req` follows the NBYTES-th slave byte. `s_wr_req` follows `s_wr_ready`.
- R4: Byte k received by the slave (`s_rx_valid`) is compared with 0xA5+k. `led_m2s` holds the first such byte until the next `start`, which clears it.
- R5: A mismatching master-to-slave byte sets `err`.
- R6: `s_data` is 0xA5 when `s_wr_req` pulses, and 0xA5+k after k `s_tx_next` strobes.
- R7: Byte k received by the master (`m_rx_valid`) is compared with 0xA5+k, and a mismatch sets `err`. `led_s2m` holds the first such byte.
- R8: After the last master byte, `done` stays low while `m_busy` is high. It rises in the cycle after `m_busy` is sampled low.
- R9: `err` stays set until the next accepted `start`. `pass` is high exactly when `done` is high and `err` is low.
- R10: A wait state held for TO_LIMIT cycles ends the run with `done`=1 and `err`=1. With no `m_wr_done`, `done` appears TO_LIMIT+1 cycles after the `m_wr_req` pulse.
- R11: A receive strobe outside its own phase is neither compared nor counted. A stray zero byte gives no error and does not change the LEDs.
- R12: A `start` during a run is ignored. It produces no new request and does not move `m_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches a run from idle or done |
| m_wr_req | output | 1 | Master write request pulse |
| m_rd_req | output | 1 | Master read request pulse |
| m_cmd | output | 8 | Command byte for the master |
| m_nbytes | output | $clog2(NBYTES+1) | Byte count for the master |
| m_data | output | 8 | Byte the master transmits next |
| m_tx_next | input | 1 | Master consumed `m_data` |
| m_wr_done | input | 1 | Master finished its write |
| m_rx_valid | input | 1 | Master received a byte |
| m_rx_data | input | 8 | Byte received by the master |
| m_busy | input | 1 | Master transaction in progress |
| s_rd_ready | input | 1 | Slave holds received data |
| s_rd_req | output | 1 | Slave read request pulse |
| s_rx_valid | input | 1 | Slave delivers a received byte |
| s_rx_data | input | 8 | Byte received by the slave |
| s_wr_ready | input | 1 | Slave ready to accept reply data |
| s_wr_req | output | 1 | Slave write request pulse |
| s_data | output | 8 | Byte the slave returns next |
| s_tx_next | input | 1 | Slave consumed `s_data` |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished without error |
| err | output | 1 | Sticky error flag |
| led_m2s | output | 8 | First byte the slave received |
| led_s2m | output | 8 | First byte the master received |

## Verification
Each request pulse appears in the cycle after the input that causes it is sampled. `m_data` and `s_data` move in the cycle after a `*_tx_next` strobe, and `done` rises one cycle after `m_busy` is seen low. After a stall, `done` arrives exactly TO_LIMIT+1 cycles after the write request.

The bench drives inputs and reads outputs only on falling edges. Each check is placed on the negedge that follows the rising edge where the result becomes due. A scoreboard queue holds the request expected next, and a monitor compares every request pulse against it, so an extra, missing or misordered pulse is caught in its own cycle.

// File: rtl/i2c_lb_pkg.sv
package i2c_lb_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_MWR,
    ST_WDONE,
    ST_SRDY,
    ST_SRD,
    ST_SRX,
    ST_MRD,
    ST_SWRDY,
    ST_SWR,
    ST_MRX,
    ST_BUSY,
    ST_DONE
  } lb_state_e;

  // Byte at position idx of the test pattern
  function automatic logic [7:0] lb_pattern(input logic [7:0] seed, input logic [7:0] idx);
    return seed + idx;
  endfunction

  // States in which the sequencer waits on a handshake
  function automatic logic lb_is_wait(input lb_state_e s);
    return (s == ST_WDONE) || (s == ST_SRDY) || (s == ST_SRX) ||
           (s == ST_SWRDY) || (s == ST_MRX) || (s == ST_BUSY);
  endfunction

endpackage

// File: rtl/lb_tx_index.sv
module lb_tx_index
  import i2c_lb_pkg::*;
#(
  parameter int unsigned NBYTES = 4,
  parameter logic [7:0]  SEED   = 8'hA5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       adv,
  output logic [7:0] data
);
  localparam int unsigned NW = $clog2(NBYTES + 1);

  logic [NW-1:0] idx;
  logic          at_end;

  assign at_end = (idx == NW'(NBYTES - 1));
  assign data   = lb_pattern(SEED, 8'(idx));

  always_ff @(posedge clk) begin
    if (rst || clear)          idx <= '0;
    else if (adv && !at_end)   idx <= idx + 1'b1;
  end

  assert_idx_bound_R2: assert property (@(posedge clk) disable iff (rst)
    idx < NW'(NBYTES));

endmodule

// File: rtl/lb_rx_check.sv
module lb_rx_check
  import i2c_lb_pkg::*;
#(
  parameter int unsigned NBYTES = 4,
  parameter logic [7:0]  SEED   = 8'hA5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       en,
  input  logic       valid,
  input  logic [7:0] data,
  output logic       last,
  output logic       mism,
  output logic [7:0] first
);
  localparam int unsigned NW = $clog2(NBYTES + 1);

  logic [NW-1:0] idx;
  logic          hit;
  logic [7:0]    exp_byte;

  assign hit      = en && valid;
  assign exp_byte = lb_pattern(SEED, 8'(idx));
  assign mism     = hit && (data != exp_byte);
  assign last     = hit && (idx == NW'(NBYTES - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx   <= '0;
      first <= '0;
    end else if (hit) begin
      if (!last)       idx   <= idx + 1'b1;
      if (idx == '0)   first <= data;
    end
  end

  // The display byte only moves on the first accepted byte or a clear
  assert_first_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(first) |-> $past(clear) || $past(hit && idx == '0));

endmodule

// File: rtl/lb_timeout.sv
module lb_timeout #(
  parameter int unsigned LIMIT = 1 << 20
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic expired
);
  localparam int unsigned TW = $clog2(LIMIT + 1);

  logic [TW-1:0] cnt;

  assign expired = run && (cnt == TW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || restart) cnt <= '0;
    else if (!expired)          cnt <= cnt + 1'b1;
  end

  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (rst)
    cnt < TW'(LIMIT));

endmodule

// File: rtl/i2c_loopback_seq.sv
module i2c_loopback_seq
  import i2c_lb_pkg::*;
#(
  parameter int unsigned NBYTES   = 4,
  parameter logic [7:0]  SEED     = 8'hA5,
  parameter logic [7:0]  CMD      = 8'h5A,
  parameter int unsigned TO_LIMIT = 1 << 20,
  localparam int unsigned NW      = $clog2(NBYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          m_wr_req,
  output logic          m_rd_req,
  output logic [7:0]    m_cmd,
  output logic [NW-1:0] m_nbytes,
  output logic [7:0]    m_data,
  input  logic          m_tx_next,
  input  logic          m_wr_done,
  input  logic          m_rx_valid,
  input  logic [7:0]    m_rx_data,
  input  logic          m_busy,
  input  logic          s_rd_ready,
  output logic          s_rd_req,
  input  logic          s_rx_valid,
  input  logic [7:0]    s_rx_data,
  input  logic          s_wr_ready,
  output logic          s_wr_req,
  output logic [7:0]    s_data,
  input  logic          s_tx_next,
  output logic          done,
  output logic          pass,
  output logic          err,
  output logic [7:0]    led_m2s,
  output logic [7:0]    led_s2m
);

  lb_state_e st, nxt_norm, nxt;

  // Named internal events
  logic go, idle_like;
  logic m2s_last, m2s_mism, s2m_last, s2m_mism;
  logic tmo_run, tmo_exp, tmo_hit;
  logic m_adv, s_adv, m2s_en, s2m_en;

  assign idle_like = (st == ST_IDLE) || (st == ST_DONE);
  assign go        = start && idle_like;
  assign m_adv     = m_tx_next && ((st == ST_MWR) || (st == ST_WDONE));
  assign s_adv     = s_tx_next && ((st == ST_SWR) || (st == ST_MRX));
  assign m2s_en    = (st == ST_SRD) || (st == ST_SRX);
  assign s2m_en    = (st == ST_SWR) || (st == ST_MRX);
  assign tmo_run   = lb_is_wait(st);

  always_comb begin
    nxt_norm = st;
    case (st)
      ST_IDLE, ST_DONE: if (start) nxt_norm = ST_MWR;
      ST_MWR:           nxt_norm = ST_WDONE;
      ST_WDONE:         if (m_wr_done) nxt_norm = ST_SRDY;
      ST_SRDY:          if (s_rd_ready) nxt_norm = ST_SRD;
      ST_SRD:           nxt_norm = m2s_last ? ST_MRD : ST_SRX;
      ST_SRX:           if (m2s_last) nxt_norm = ST_MRD;
      ST_MRD:           nxt_norm = ST_SWRDY;
      ST_SWRDY:         if (s_wr_ready) nxt_norm = ST_SWR;
      ST_SWR:           nxt_norm = s2m_last ? ST_BUSY : ST_MRX;
      ST_MRX:           if (s2m_last) nxt_norm = ST_BUSY;
      ST_BUSY:          if (!m_busy) nxt_norm = ST_DONE;
      default:          nxt_norm = ST_IDLE;
    endcase
  end

  assign tmo_hit = tmo_exp && (nxt_norm == st);
  assign nxt     = tmo_hit ? ST_DONE : nxt_norm;

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= nxt;
  end

  always_ff @(posedge clk) begin
    if (rst || go)                             err <= 1'b0;
    else if (m2s_mism || s2m_mism || tmo_hit)  err <= 1'b1;
  end

  assign m_wr_req = (st == ST_MWR);
  assign m_rd_req = (st == ST_MRD);
  assign s_rd_req = (st == ST_SRD);
  assign s_wr_req = (st == ST_SWR);
  assign m_cmd    = CMD;
  assign m_nbytes = NW'(NBYTES);
  assign done     = (st == ST_DONE);
  assign pass     = done && !err;

  lb_tx_index #(.NBYTES(NBYTES), .SEED(SEED)) u_m_feed (
    .clk(clk), .rst(rst), .clear(go), .adv(m_adv), .data(m_data)
  );

  lb_tx_index #(.NBYTES(NBYTES), .SEED(SEED)) u_s_feed (
    .clk(clk), .rst(rst), .clear(go), .adv(s_adv), .data(s_data)
  );

  lb_rx_check #(.NBYTES(NBYTES), .SEED(SEED)) u_m2s_chk (
    .clk(clk), .rst(rst), .clear(go), .en(m2s_en), .valid(s_rx_valid),
    .data(s_rx_data), .last(m2s_last), .mism(m2s_mism), .first(led_m2s)
  );

  lb_rx_check #(.NBYTES(NBYTES), .SEED(SEED)) u_s2m_chk (
    .clk(clk), .rst(rst), .clear(go), .en(s2m_en), .valid(m_rx_valid),
    .data(m_rx_data), .last(s2m_last), .mism(s2m_mism), .first(led_s2m)
  );

  lb_timeout #(.LIMIT(TO_LIMIT)) u_tmo (
    .clk(clk), .rst(rst), .run(tmo_run), .restart(nxt_norm != st), .expired(tmo_exp)
  );

  assert_wr_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    m_wr_req |=> !m_wr_req);

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    err && !go |=> err);

  assert_timeout_end_R10: assert property (@(posedge clk) disable iff (rst)
    tmo_hit |=> done && err);

  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(done) && !$past(tmo_hit) |-> !$past(m_busy));

  assert_start_ignored_R12: assert property (@(posedge clk) disable iff (rst)
    start && !idle_like |=> !m_wr_req);

endmodule

// File: tb/i2c_loopback_seq_bench.sv
module i2c_loopback_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int TO = 300;
  localparam logic [7:0] SD = 8'hA5;
  localparam logic [7:0] CM = 8'h5A;
  localparam int NW = $clog2(NB + 1);

  logic clk = 0, rst = 1, start = 0;
  logic m_wr_req, m_rd_req, s_rd_req, s_wr_req, done, pass, err;
  logic [7:0] m_cmd, m_data, s_data, led_m2s, led_s2m;
  logic [NW-1:0] m_nbytes;
  logic m_tx_next = 0, m_wr_done = 0, m_rx_valid = 0, m_busy = 0;
  logic s_rd_ready = 0, s_rx_valid = 0, s_wr_ready = 0, s_tx_next = 0;
  logic [7:0] m_rx_data = 0, s_rx_data = 0;

  int total = 0, bad = 0;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_loopback_seq #(.NBYTES(NB), .SEED(SD), .CMD(CM), .TO_LIMIT(TO)) u_i2c_loopback_seq (
    .clk(clk), .rst(rst), .start(start),
    .m_wr_req(m_wr_req), .m_rd_req(m_rd_req), .m_cmd(m_cmd), .m_nbytes(m_nbytes),
    .m_data(m_data), .m_tx_next(m_tx_next), .m_wr_done(m_wr_done),
    .m_rx_valid(m_rx_valid), .m_rx_data(m_rx_data), .m_busy(m_busy),
    .s_rd_ready(s_rd_ready), .s_rd_req(s_rd_req), .s_rx_valid(s_rx_valid),
    .s_rx_data(s_rx_data), .s_wr_ready(s_wr_ready), .s_wr_req(s_wr_req),
    .s_data(s_data), .s_tx_next(s_tx_next), .done(done), .pass(pass), .err(err),
    .led_m2s(led_m2s), .led_s2m(led_s2m)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [7:0] pat(input int k);
    return 8'((int'(SD) + k) % 256);
  endfunction

  // Monitor: every request pulse pops the expected code (1 mwr, 2 mrd, 3 srd, 4 swr)
  always @(negedge clk) begin
    if (!rst) begin
      int code;
      code = m_wr_req ? 1 : m_rd_req ? 2 : s_rd_req ? 3 : s_wr_req ? 4 : 0;
      if ((m_wr_req + m_rd_req + s_rd_req + s_wr_req) > 1)
        chk(0, "R3 several requests", code, 0);
      if (code != 0) begin
        if (exp_q.size() == 0) chk(0, "R3/R12 unexpected request", code, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(code == e, "R3 request order", code, e);
        end
      end
    end
  end

  task automatic run_full(input int bad_m2s, input int bad_s2m, input bit poke);
    m_busy = 1;
    exp_q.push_back(1);
    start = 1; step(); start = 0;
    chk(m_wr_req == 1, "R2 write request", m_wr_req, 1);
    chk(m_data == SD, "R2 first data", m_data, SD);
    chk(m_cmd == CM && m_nbytes == NW'(NB), "R2 cmd/count", {m_cmd, 8'(m_nbytes)}, {CM, 8'(NB)});
    chk(led_m2s == 0 && led_s2m == 0, "R4 leds cleared by start", {led_m2s, led_s2m}, 0);
    for (int k = 1; k < NB; k++) begin
      m_tx_next = 1; step(); m_tx_next = 0;
      chk(m_data == pat(k), "R2 data advance", m_data, pat(k));
    end
    if (poke) begin
      start = 1; step(); start = 0; step();
      chk(m_data == pat(NB-1), "R12 start ignored", m_data, pat(NB-1));
    end
    m_wr_done = 1; step(); m_wr_done = 0;
    s_rx_valid = 1; s_rx_data = 8'h00; step(); s_rx_valid = 0;
    exp_q.push_back(3);
    s_rd_ready = 1;
    while (!s_rd_req) step();
    s_rd_ready = 0;
    for (int k = 0; k < NB; k++) begin
      s_rx_valid = 1;
      s_rx_data = pat(k) ^ ((k == bad_m2s) ? 8'hFF : 8'h00);
      if (k == NB-1) exp_q.push_back(2);
      step();
      s_rx_valid = 0;
    end
    chk(led_m2s == SD, "R4 first slave byte", led_m2s, SD);
    chk(m_rd_req == 1, "R3 read request after last byte", m_rd_req, 1);
    m_rx_valid = 1; m_rx_data = 8'h00; step(); m_rx_valid = 0;
    chk(led_s2m == 0, "R11 stray strobe ignored", led_s2m, 0);
    exp_q.push_back(4);
    s_wr_ready = 1;
    while (!s_wr_req) step();
    s_wr_ready = 0;
    chk(s_data == SD, "R6 slave first data", s_data, SD);
    for (int k = 1; k < NB; k++) begin
      s_tx_next = 1; step(); s_tx_next = 0;
      chk(s_data == pat(k), "R6 slave data advance", s_data, pat(k));
    end
    for (int k = 0; k < NB; k++) begin
      m_rx_valid = 1;
      m_rx_data = pat(k) ^ ((k == bad_s2m) ? 8'h0F : 8'h00);
      step();
      m_rx_valid = 0;
    end
    chk(led_s2m == SD, "R7 first master byte", led_s2m, SD);
    for (int k = 0; k < 3; k++) begin
      step();
      chk(done == 0, "R8 done held by busy", done, 0);
    end
    m_busy = 0; step();
    chk(done == 1, "R8 done after busy low", done, 1);
    if (bad_m2s >= 0) chk(err == 1, "R5 m2s mismatch err", err, 1);
    else if (bad_s2m >= 0) chk(err == 1, "R7 s2m mismatch err", err, 1);
    else chk(err == 0, "R11 clean run no err", err, 0);
    chk(pass == (bad_m2s < 0 && bad_s2m < 0), "R9 pass", pass, (bad_m2s < 0 && bad_s2m < 0));
    step();
    chk(done == 1 && err == (bad_m2s >= 0 || bad_s2m >= 0), "R9 err sticky in done", err, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    step(); step();
    chk(!m_wr_req && !m_rd_req && !s_rd_req && !s_wr_req, "R1 requests in reset", 0, 0);
    chk(!done && !pass && !err, "R1 flags in reset", {done, pass, err}, 0);
    rst = 0; step();
    chk(!done && !err && led_m2s == 0 && led_s2m == 0, "R1 after reset", {done, err}, 0);

    run_full(-1, -1, 1);
    run_full(2, -1, 0);
    run_full(-1, 1, 0);

    // Timeout: the master never reports write completion
    exp_q.push_back(1);
    m_busy = 1;
    start = 1; step(); start = 0;
    n = 0;
    while (!done) begin step(); n++; end
    chk(n == TO + 1, "R10 timeout latency", n, TO + 1);
    chk(err == 1 && pass == 0, "R10 timeout error", {err, pass}, 2);

    run_full(-1, -1, 0);
    chk(err == 0, "R9 err cleared by start", err, 0);

    step();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule